// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a two-wire bus target that puts a small byte-wide storage array on the bus. The array holds 512 bytes by default, or 1024 bytes when the wide variant is chosen. The bus lines arrive as ordinary inputs and are sampled by a much faster system clock. The block pulls SDA low through a single output enable, and the pad provides the open-drain behaviour.

A transfer opens with a START condition and a device-address byte. In the upper nibble of that byte the block expects the type code 1010. The next bits carry the top bits of the storage address, and the last bit chooses reading or writing. A write transfer supplies the low eight bits of the address and then any number of data bytes. A read transfer streams bytes from an internal pointer for as long as the bus controller acknowledges. A random read is a write transfer that carries only the address, followed by a repeated START and a read. A write-protect input turns every store into a no-op, and the bus still sees each byte acknowledged.

Top module: `i2c_ee_target`

## Requirements
- R1: After reset `sda_oe_o` is 0. Until a START is seen (SDA falling while SCL is high), the block never asserts `sda_oe_o`, and clocked bytes get no acknowledge.
- R2: The device byte is sent MSB first and must read 1010, 0, 0, a8, R/W in the default variant (0, a9, a8 in the wide variant). On a match the block pulls SDA low (ACK) during the 9th SCL clock. On any other value SDA stays high, and every later byte is ignored until the next START.
- R3: In a write transfer (R/W = 0), the second byte gives address bits 7..0, and a8 from the device byte supplies the upper bit. Each following data byte is stored at the pointer and acknowledged, and the pointer then advances by one.
- R4: The pointer wraps from the last location (0x1FF by default) to 0x000, both in writing and in reading.
- R5: A random read is a write-mode device byte, an address byte, a repeated START and a read-mode device byte (R/W = 1). It returns the byte at the address just set.
- R6: A read-mode device byte with no address phase returns the byte at the current pointer. The pointer is where the last access left it, and the upper bits of a read device byte do not change it.
- R7: Read data is sent MSB first. After each byte the controller's ACK (SDA low) starts the next byte at the incremented pointer. After a NoACK the block releases SDA and drives nothing more.
- R8: While `wp_i` is 1, data bytes are still acknowledged, but the storage is left unchanged.
- R9: A STOP (SDA rising while SCL is high) at any point returns the block to idle and releases SDA. A partly received data byte is not stored.
- R10: `sda_oe_o` changes only while SCL is low, so SDA stays stable through every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| wp_i | input | 1 | Write protect, 1 blocks all stores |
| sda_oe_o | output | 1 | 1 pulls the SDA line low |

## Verification
A pin change reaches the protocol logic after two synchroniser stages and one edge register. The state, and with it `sda_oe_o`, therefore moves about three system clocks after the SCL falling edge that causes it. The bench drives pins on the falling system-clock edge and holds each SCL low phase for four clocks, so the block has settled before SCL rises. It reads acknowledge and data bits in the middle of the SCL high phase, at least eight clocks after the preceding SCL fall. The per-clock comparisons of `sda_oe_o` against the bench's bus model are taken 2 ns after each rising clock edge, so they are never sampled at an edge.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } ee_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_ee_rst_sync.sv
module i2c_ee_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic prev_o
);

  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      cell_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = cell_q[addr_i];

endmodule

// File: rtl/i2c_ee_fsm.sv
module i2c_ee_fsm
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_prev,
  input  logic              sda_lvl,
  input  logic              sda_prev,
  input  logic              wp_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              sda_oe_o
);

  localparam int UPPER_W = ADDR_W - BYTE_W;
  localparam int PAD_LO  = UPPER_W + 1;
  localparam logic [3:0] BITS_IN = 4'd8;
  localparam logic [3:0] BITS_OUT_LAST = 4'd7;

  ee_state_e           state_q, state_d;
  logic [3:0]          cnt_q, cnt_d;
  logic [BYTE_W-1:0]   sh_q, sh_d;
  logic [BYTE_W-1:0]   tx_q, tx_d;
  logic [ADDR_W-1:0]   ptr_q, ptr_d;
  logic [UPPER_W-1:0]  hi_q, hi_d;
  logic                rw_q, rw_d;
  logic                mack_q, mack_d;
  logic                we;

  logic scl_rise, scl_fall, start_evt, stop_evt, dev_match, byte_done;

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
  assign dev_match = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:PAD_LO] == '0);
  assign byte_done = scl_fall && (cnt_q == BITS_IN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    hi_d    = hi_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    we      = 1'b0;
    if (stop_evt) begin
      state_d = ST_IDLE;
    end else if (start_evt) begin
      state_d = ST_DEV;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_IDLE;
        end
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 4'd1;
          end else if (byte_done) begin
            cnt_d = '0;
            if (state_q == ST_DEV) begin
              if (dev_match) begin
                hi_d    = sh_q[UPPER_W:1];
                rw_d    = sh_q[0];
                state_d = ST_DEV_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_WADDR) begin
              ptr_d   = {hi_q, sh_q};
              state_d = ST_WADDR_ACK;
            end else begin
              we      = ~wp_i;
              ptr_d   = ptr_q + ADDR_W'(1);
              state_d = ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              tx_d    = mem_rdata_i;
              ptr_d   = ptr_q + ADDR_W'(1);
              state_d = ST_RDATA;
            end else begin
              state_d = ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            cnt_d   = '0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == BITS_OUT_LAST) begin
              cnt_d   = '0;
              state_d = ST_RACK;
            end else begin
              tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_d    = mem_rdata_i;
              ptr_d   = ptr_q + ADDR_W'(1);
              state_d = ST_RDATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      hi_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      hi_q    <= hi_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
      ST_RDATA:                               sda_oe_o = ~tx_q[BYTE_W-1];
      default:                                sda_oe_o = 1'b0;
    endcase
  end

  assign mem_we_o    = we;
  assign mem_addr_o  = ptr_q;
  assign mem_wdata_o = sh_q;
  assign start_o     = start_evt;
  assign stop_o      = stop_evt;

endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target
  import i2c_ee_pkg::*;
#(
  parameter bit WIDE_MEM    = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);

  localparam int ADDR_W = WIDE_MEM ? 10 : 9;
  localparam int N_PINS = 2;

  logic              rst_sync_n;
  logic [N_PINS-1:0] pin_raw, pin_lvl, pin_prev;
  logic              scl_lvl, scl_prev, sda_lvl, sda_prev;
  logic              start_evt, stop_evt;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [BYTE_W-1:0] mem_wdata, mem_rdata;

  i2c_ee_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign pin_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin_sync
    i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .d_i    (pin_raw[g]),
      .lvl_o  (pin_lvl[g]),
      .prev_o (pin_prev[g])
    );
  end

  assign scl_lvl  = pin_lvl[0];
  assign scl_prev = pin_prev[0];
  assign sda_lvl  = pin_lvl[1];
  assign sda_prev = pin_prev[1];

  i2c_ee_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .scl_lvl     (scl_lvl),
    .scl_prev    (scl_prev),
    .sda_lvl     (sda_lvl),
    .sda_prev    (sda_prev),
    .wp_i        (wp_i),
    .mem_rdata_i (mem_rdata),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .start_o     (start_evt),
    .stop_o      (stop_evt),
    .sda_oe_o    (sda_oe_o)
  );

  i2c_ee_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              wp_i,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_rdata,
  input logic              sda_oe_o
);

  logic in_xfer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_xfer_q <= 1'b0;
    end else if (stop_evt) begin
      in_xfer_q <= 1'b0;
    end else if (start_evt) begin
      in_xfer_q <= 1'b1;
    end
  end

  assert_quiet_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> in_xfer_q);

  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe_o);

  assert_oe_stable_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && !$past(start_evt) && !$past(stop_evt))
      |-> $stable(sda_oe_o));

  assert_wp_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wp_i) && $stable(mem_addr)) |-> $stable(mem_rdata));

endmodule

bind i2c_ee_target i2c_ee_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scl_lvl   (scl_lvl),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .wp_i      (wp_i),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata),
  .sda_oe_o  (sda_oe_o)
);

// File: tb/i2c_ee_target_bench.sv
module i2c_ee_target_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_ee_target u_i2c_ee_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .wp_i     (wp),
    .sda_oe_o (sda_oe)
  );

  int checks = 0;
  int errors = 0;
  int r10_viol = 0;
  int r1_viol = 0;
  logic in_xfer_m = 1'b0;
  logic scl_prev_s = 1'b1;
  logic oe_prev_s = 1'b0;
  logic [7:0] ref_mem [512];
  int ref_ptr = 0;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock bus model: SDA may move only while SCL is low, and never outside a transfer
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (scl_m && scl_prev_s && (sda_oe != oe_prev_s)) r10_viol++;
      if (sda_oe && !in_xfer_m) r1_viol++;
    end
    scl_prev_s = scl_m;
    oe_prev_s  = sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(6);
    sda_m = 1'b0; in_xfer_m = 1'b1; tick(6);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(6);
    sda_m = 1'b1; tick(6);
    in_xfer_m = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(4);
    scl_m = 1'b1; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(4);
    ack = ~sda_bus; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(4);
      scl_m = 1'b1; tick(4);
      b[i] = sda_bus; tick(4);
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(4);
    scl_m = 1'b1; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  function automatic logic [7:0] dev_byte(input int addr, input logic rd);
    return {4'b1010, 2'b00, 1'(addr >> 8), rd};
  endfunction

  task automatic do_write(input int addr, input int n, input int base, input string req);
    logic ack;
    logic [7:0] v;
    bus_start();
    wr_byte(dev_byte(addr, 1'b0), ack);
    chk(ack, {req, " device ack"}, ack, 1);
    wr_byte(8'(addr), ack);
    chk(ack, {req, " address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      v = 8'(base + i * 8'h11);
      wr_byte(v, ack);
      chk(ack, {req, " data ack"}, ack, 1);
      if (!wp) ref_mem[(addr + i) % 512] = v;
    end
    bus_stop();
    ref_ptr = (addr + n) % 512;
  endtask

  task automatic do_rread(input int addr, input int n, input string req);
    logic ack;
    logic [7:0] b;
    bus_start();
    wr_byte(dev_byte(addr, 1'b0), ack);
    chk(ack, {req, " device ack"}, ack, 1);
    wr_byte(8'(addr), ack);
    chk(ack, {req, " address ack"}, ack, 1);
    bus_start();
    wr_byte(dev_byte(addr, 1'b1), ack);
    chk(ack, {req, " read device ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n - 1, b);
      chk(b == ref_mem[(addr + i) % 512], {req, " read data"}, b, ref_mem[(addr + i) % 512]);
    end
    chk(sda_oe == 1'b0, "R7 released after NoACK", sda_oe, 0);
    bus_stop();
    ref_ptr = (addr + n) % 512;
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

    // R1: bytes clocked without any START are not acknowledged
    scl_m = 1'b0; tick(4);
    wr_byte(8'hA2, ack);
    chk(ack == 1'b0, "R1 no START no ack", ack, 0);
    sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(8);

    // R2: type code and padding bits must match
    bus_start();
    wr_byte(8'hB2, ack);
    chk(ack == 1'b0, "R2 wrong type code", ack, 0);
    wr_byte(8'hA2, ack);
    chk(ack == 1'b0, "R2 ignored until next START", ack, 0);
    bus_stop();
    bus_start();
    wr_byte(8'hA6, ack);
    chk(ack == 1'b0, "R2 padding bit set", ack, 0);
    bus_stop();

    // R3: byte writes with a8 = 1
    do_write(32'h110, 4, 8'h11, "R3");

    // R5, R7: random read with sequential continuation
    do_rread(32'h110, 3, "R5");

    // R6: current-address read, device byte upper bit ignored
    bus_start();
    wr_byte(8'hA1, ack);
    chk(ack, "R6 device ack", ack, 1);
    rd_byte(1'b0, b);
    chk(b == ref_mem[ref_ptr], "R6 current address data", b, ref_mem[ref_ptr]);
    bus_stop();
    ref_ptr = (ref_ptr + 1) % 512;

    // R4: wrap at the top of the array in write and read
    do_write(32'h1FF, 2, 8'h5A, "R4");
    chk(ref_mem[0] == 8'h6B, "R4 model wrap", ref_mem[0], 8'h6B);
    do_rread(32'h1FF, 2, "R4");

    // R8: write protect acknowledges but does not store
    wp = 1'b1;
    do_write(32'h110, 2, 8'h99, "R8");
    wp = 1'b0;
    do_rread(32'h110, 2, "R8");

    // R9: STOP inside a data byte drops it and returns to idle
    bus_start();
    wr_byte(8'hA2, ack);
    chk(ack, "R9 device ack", ack, 1);
    wr_byte(8'h12, ack);
    chk(ack, "R9 address ack", ack, 1);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    chk(sda_oe == 1'b0, "R9 released after STOP", sda_oe, 0);
    scl_m = 1'b0; tick(4);
    wr_byte(8'hFF, ack);
    chk(ack == 1'b0, "R9 idle after STOP", ack, 0);
    sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(8);
    do_rread(32'h112, 1, "R9");

    chk(r10_viol == 0, "R10 SDA stable while SCL high", r10_viol, 0);
    chk(r1_viol == 0, "R1 no drive outside transfer", r1_viol, 0);
    finish_run();
  end

endmodule